// File: doc/BRIEF.md
# Serial-Bus Control Register Target with Write and Read Windows

This block is a two-wire serial bus target (I2C protocol, standard and fast mode up to 400 kHz) that owns a bank of 8-bit control registers and exposes a small set of read-only status bytes. The master addresses it with a 7-bit device address of the form `1101s11`, where `s` comes from the `addr_sel` strap pin. Two copies of the block can therefore share one bus, answering at write address bytes D6h and DEh.

A write transfer carries a subaddress byte followed by any number of data bytes. Each byte is acknowledged, and the internal pointer advances after every data byte. Only subaddresses 00h to 21h hold storage. Bytes aimed elsewhere are acknowledged and then dropped. A combined transfer reads status. The master first sets the pointer with a write of the subaddress alone, issues a repeated START, and then clocks out bytes. Status lives at 28h, 2Ah, 2Bh and 2Ch. Every other subaddress reads as 00h, including the control registers.

The register contents appear on a flat output bus for the rest of the chip. The bus lines pass through a two-stage synchronizer on the system clock. START and STOP are recognised from SDA edges while SCL is high. SDA is driven open-drain through an output-enable pin. SCL is never driven, since there is no clock stretching.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block acknowledges (holds SDA low through the 9th SCL pulse) an address byte whose upper seven bits equal `1101s11`, with `s` = `addr_sel` at bit 2 of the 7-bit address, so the write byte is D6h for `addr_sel`=0 and DEh for `addr_sel`=1.
- R2: After an address byte that does not match, the block never drives SDA, and no register changes, until the next START or STOP.
- R3: In a write transfer, the subaddress byte and each data byte are acknowledged, and the first data byte is stored in the register at that subaddress; register n appears on `regs_o[8n+7:8n]`.
- R4: The pointer advances by one after each data byte, so a burst fills consecutive subaddresses.
- R5: Data bytes at subaddresses above 21h are acknowledged but leave every register unchanged, even when a burst crosses the 21h boundary.
- R6: After a repeated START with the read bit set, the block returns status bytes from the pointer: 28h gives `status_i[7:0]`, 2Ah gives `status_i[15:8]`, 2Bh gives `status_i[23:16]`, and 2Ch gives `status_i[31:24]`, most significant bit first.
- R7: Any other subaddress reads as 00h, control registers included, and the pointer advances by one after each byte read.
- R8: On synchronous reset, register 00h holds 01h, 01h holds 40h, 03h holds 80h, and all other registers hold 00h; SDA is released.
- R9: A master NACK ends a read with SDA released. After a STOP, bytes clocked without a new START are not acknowledged.
- R10: SDA driven by the block changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low (open-drain) |
| addr_sel | input | 1 | Strap that selects bit 2 of the device address |
| status_i | input | 32 | Four read-only status bytes, byte 0 in the low bits |
| regs_o | output | 272 | Flat control register bus, 34 bytes, subaddress 00h in the low bits |

## Verification
The hardest case to reach from the ports is a read burst in which the pointer walks past a status subaddress, across a gap, and on into the next status byte. In that burst the master acknowledges every byte but the last. The bench sets the pointer to 28h, issues a repeated START and reads five bytes in one go, expecting the gap byte at 29h to come back 00h. A second hard case is a write burst that starts two bytes below the top of the write window. The bench checks that the overflow byte is acknowledged and that the register bank shows no trace of it. A bus model with wired-AND drive samples SDA twice in each high phase of SCL, which catches any change of the block's drive while the clock is high.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned STRAP_BIT = 2;
    localparam int unsigned STAT_N    = 4;

    localparam logic [7:0] STAT_ADDR [STAT_N] = '{8'h28, 8'h2A, 8'h2B, 8'h2C};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } xfer_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic       stb;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic strap);
        logic [6:0] a;
        a = base;
        a[STRAP_BIT] = strap;
        return a;
    endfunction

    function automatic logic in_window(input logic [7:0] a, input logic [7:0] lo,
                                       input logic [7:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync
    import i2c_rb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int unsigned N = SYNC_STAGES;

    logic [N:0] scl_v;
    logic [N:0] sda_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_v <= '1;
            sda_v <= '1;
        end else begin
            scl_v <= {scl_v[N-1:0], scl_i};
            sda_v <= {sda_v[N-1:0], sda_i};
        end
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign scl_s = scl_v[N-1];
    assign scl_q = scl_v[N];
    assign sda_s = sda_v[N-1];
    assign sda_q = sda_v[N];

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'b1101011
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       strap,
    input  logic [7:0] rd_data,
    output wr_req_t    wr,
    output logic [7:0] ptr,
    output logic       sda_oe
);
    localparam logic [3:0] FULL = 4'(BYTE_W);

    xfer_state_e state;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic        rw_q;
    logic        mack_q;

    logic [6:0] my_addr;
    logic       rx_phase;
    logic       byte_full;

    assign my_addr   = dev_addr(DEV_BASE, strap);
    assign rx_phase  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);
    assign byte_full = (bitcnt == FULL);

    always_ff @(posedge clk) begin
        wr.stb <= 1'b0;
        if (rst) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            ptr    <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else if (evt.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            if (rx_phase && evt.scl_rise && !byte_full) begin
                shreg  <= {shreg[6:0], evt.sda};
                bitcnt <= bitcnt + 4'd1;
            end
            unique case (state)
                ST_ADDR: begin
                    if (evt.scl_fall && byte_full) begin
                        bitcnt <= '0;
                        if (shreg[7:1] == my_addr) begin
                            sda_oe <= 1'b1;
                            rw_q   <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_SUB: begin
                    if (evt.scl_fall && byte_full) begin
                        bitcnt <= '0;
                        ptr    <= shreg;
                        sda_oe <= 1'b1;
                        state  <= ST_SUB_ACK;
                    end
                end
                ST_WDATA: begin
                    if (evt.scl_fall && byte_full) begin
                        bitcnt  <= '0;
                        wr.stb  <= 1'b1;
                        wr.addr <= ptr;
                        wr.data <= shreg;
                        ptr     <= ptr + 8'd1;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        if (rw_q) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= 4'd1;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_fall) begin
                        if (byte_full) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 8'd1;
                            state  <= ST_RDATA_ACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (evt.scl_rise) begin
                        mack_q <= ~evt.sda;
                    end
                    if (evt.scl_fall) begin
                        if (mack_q) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= 4'd1;
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: a matched address is acknowledged for the whole ack slot
    p_ack_matched_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK) |-> sda_oe);

    // R2: an unaddressed target keeps off the bus
    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe && !wr.stb);

    // R3: register writes originate only from the data phase
    p_wr_from_data_r3: assert property (@(posedge clk) disable iff (rst)
        wr.stb |-> ($past(state) == ST_WDATA));

    // R7: read pointer steps once per transmitted byte
    p_rd_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA_ACK && $past(state) == ST_RDATA) |-> (ptr == $past(ptr) + 8'd1));

    // R10: own SDA drive moves only while SCL is low
    p_sda_move_low_r10: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !evt.scl);

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
    import i2c_rb_pkg::*;
#(
    parameter int unsigned               NUM_REGS = 34,
    parameter int unsigned               WIN_LO   = 0,
    parameter logic [NUM_REGS*8-1:0]     RST_ONES = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam logic [7:0] LO_A = 8'(WIN_LO);
    localparam logic [7:0] HI_A = 8'(WIN_LO + NUM_REGS - 1);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] MY_ADDR = 8'(WIN_LO + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[i*8 +: 8] <= RST_ONES[i*8 +: 8];
            end else if (wr.stb && (wr.addr == MY_ADDR)) begin
                regs_o[i*8 +: 8] <= wr.data;
            end
        end
    end

    // R5: a write outside the window leaves the bank untouched
    p_outside_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.stb && !in_window(wr.addr, LO_A, HI_A)) |=> (regs_o == $past(regs_o)));

endmodule

// File: rtl/i2c_rb_rdmux.sv
module i2c_rb_rdmux
    import i2c_rb_pkg::*;
(
    input  logic [7:0]          ptr,
    input  logic [STAT_N*8-1:0] status_i,
    output logic [7:0]          rd_data
);
    logic [STAT_N-1:0] hit;

    for (genvar k = 0; k < STAT_N; k++) begin : g_hit
        assign hit[k] = (ptr == STAT_ADDR[k]);
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < STAT_N; k++) begin
            if (hit[k]) rd_data = rd_data | status_i[k*8 +: 8];
        end
    end

    // R6: status slots never overlap
    always_comb begin
        p_hit_onehot_r6: assert ($onehot0(hit));
    end

    // R7: unmapped subaddresses return zero
    always_comb begin
        p_unmapped_zero_r7: assert ((|hit) || (rd_data == 8'h00));
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0]            DEV_BASE    = 7'b1101011,
    parameter int unsigned           SYNC_STAGES = 2,
    parameter int unsigned           WIN_LO      = 0,
    parameter int unsigned           NUM_REGS    = 34,
    parameter logic [NUM_REGS*8-1:0] RST_ONES    = (NUM_REGS*8)'(32'h8000_4001)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic                  addr_sel,
    input  logic [STAT_N*8-1:0]   status_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    bus_evt_t   evt;
    wr_req_t    wr;
    logic [7:0] ptr;
    logic [7:0] rd_data;

    i2c_rb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rb_engine #(.DEV_BASE(DEV_BASE)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .strap   (addr_sel),
        .rd_data (rd_data),
        .wr      (wr),
        .ptr     (ptr),
        .sda_oe  (sda_oe)
    );

    i2c_rb_regs #(
        .NUM_REGS (NUM_REGS),
        .WIN_LO   (WIN_LO),
        .RST_ONES (RST_ONES)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .regs_o (regs_o)
    );

    i2c_rb_rdmux u_rdmux (
        .ptr      (ptr),
        .status_i (status_i),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/tb_i2c_regbank_target.sv
`timescale 1ns/1ps
module tb_i2c_regbank_target;
    localparam int Q    = 8;
    localparam int NREG = 34;
    localparam logic [6:0] DEV0 = 7'h6B;  // 1101011 -> D6h
    localparam logic [6:0] DEV1 = 7'h6F;  // 1101111 -> DEh

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] data;
        logic [5:0] idx;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h00, 8'h5A, 6'd0,  8'h5A},   // R3 plain store
        '{8'h21, 8'hC3, 6'd33, 8'hC3},   // R3 top of window
        '{8'h22, 8'h77, 6'd33, 8'hC3},   // R5 just above window
        '{8'h28, 8'h11, 6'd0,  8'h5A},   // R5 status address not writable
        '{8'h10, 8'hFF, 6'd16, 8'hFF},   // R3 mid bank
        '{8'h01, 8'h00, 6'd1,  8'h00}    // R3 clears a reset-one register
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, m_scl_low, m_sda_low, addr_sel, sda_oe;
    logic [31:0] status_i;
    logic [NREG*8-1:0] regs_o;
    logic scl_bus, sda_bus;
    assign scl_bus = ~m_scl_low;
    assign sda_bus = ~(m_sda_low | sda_oe);

    i2c_regbank_target dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_bus),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .status_i (status_i),
        .regs_o   (regs_o)
    );

    int n_chk = 0, n_fail = 0, r10_glitch = 0;
    bit done = 0;
    logic [7:0] mdl [NREG];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic reset_model();
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        mdl[0] = 8'h01; mdl[1] = 8'h40; mdl[3] = 8'h80;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a <= 8'h21) mdl[a] = d;
    endtask

    task automatic chk_bank(input string req);
        int bad = 0;
        logic [7:0] fa = 0, fe = 0;
        for (int i = 0; i < NREG; i++) begin
            if (regs_o[i*8 +: 8] !== mdl[i]) begin
                if (bad == 0) begin fa = regs_o[i*8 +: 8]; fe = mdl[i]; end
                bad++;
            end
        end
        chk(bad == 0, req, {24'h0, fa}, {24'h0, fe});
    endtask

    task automatic send_bit(input bit b);
        m_sda_low = ~b; qw();
        m_scl_low = 1'b0; qw(); qw();
        m_scl_low = 1'b1; qw();
    endtask

    task automatic rx_bit(output bit b);
        m_sda_low = 1'b0; qw();
        m_scl_low = 1'b0; qw();
        b = sda_bus; qw();
        if (sda_bus != b) r10_glitch++;
        m_scl_low = 1'b1; qw();
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; qw();
        m_scl_low = 1'b0; qw();
        m_sda_low = 1'b1; qw();
        m_scl_low = 1'b1; qw();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; qw();
        m_scl_low = 1'b0; qw();
        m_sda_low = 1'b0; qw();
    endtask

    task automatic write_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        rx_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin rx_bit(b); d[i] = b; end
        send_bit(~give_ack);
        m_sda_low = 1'b0;
    endtask

    task automatic wr_tx(input logic [6:0] dev, input logic [7:0] sub, input int n,
                         input logic [31:0] data, output int acks);
        bit a;
        acks = 0;
        i2c_start();
        write_byte({dev, 1'b0}, a); acks += int'(a);
        write_byte(sub, a); acks += int'(a);
        for (int i = 0; i < n; i++) begin
            write_byte(data[31-8*i -: 8], a); acks += int'(a);
        end
        i2c_stop();
        qw();
    endtask

    task automatic rd_tx(input logic [6:0] dev, input logic [7:0] sub, input int n,
                         output logic [39:0] got, output int acks);
        bit a;
        logic [7:0] b;
        acks = 0; got = '0;
        i2c_start();
        write_byte({dev, 1'b0}, a); acks += int'(a);
        write_byte(sub, a); acks += int'(a);
        i2c_start();
        write_byte({dev, 1'b1}, a); acks += int'(a);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            got[39-8*i -: 8] = b;
        end
        qw();
        chk(sda_oe == 1'b0, "R9 released after NACK", {31'h0, sda_oe}, 32'h0);
        i2c_stop();
        qw();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int acks;
        bit a;
        logic [39:0] got;

        rst = 1'b1; m_scl_low = 1'b0; m_sda_low = 1'b0; addr_sel = 1'b0;
        status_i = 32'hC4B3_A291;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R8 reset state
        reset_model();
        chk_bank("R8 reset values");
        chk(sda_oe == 1'b0, "R8 SDA released", {31'h0, sda_oe}, 32'h0);

        // Table walk: single-byte writes (R3, R5)
        for (int v = 0; v < 6; v++) begin
            wr_tx(DEV0, VECS[v].sub, 1, {VECS[v].data, 24'h0}, acks);
            chk(acks == 3, "R3/R5 all bytes acked", acks, 3);
            model_write(VECS[v].sub, VECS[v].data);
            chk(regs_o[VECS[v].idx*8 +: 8] == VECS[v].exp, "R3/R5 table register",
                {24'h0, regs_o[VECS[v].idx*8 +: 8]}, {24'h0, VECS[v].exp});
        end
        chk_bank("R5 bank after table");

        // R4/R5 burst across top of window
        wr_tx(DEV0, 8'h1F, 4, 32'hA1A2_A3A4, acks);
        chk(acks == 6, "R5 overflow byte acked", acks, 6);
        for (int i = 0; i < 4; i++) model_write(8'h1F + 8'(i), 8'hA1 + 8'(i));
        chk(regs_o[8'h20*8 +: 8] == 8'hA2, "R4 auto-increment", {24'h0, regs_o[8'h20*8 +: 8]}, 32'hA2);
        chk_bank("R4/R5 burst bank");

        // R1/R2 strap-selected address
        addr_sel = 1'b1;
        repeat (4) @(negedge clk);
        wr_tx(DEV1, 8'h02, 1, 32'h5C00_0000, acks);
        chk(acks == 3, "R1 DEh acked with strap=1", acks, 3);
        model_write(8'h02, 8'h5C);
        chk(regs_o[2*8 +: 8] == 8'h5C, "R1 write via DEh", {24'h0, regs_o[2*8 +: 8]}, 32'h5C);
        wr_tx(DEV0, 8'h02, 1, 32'h9900_0000, acks);
        chk(acks == 0, "R2 D6h ignored with strap=1", acks, 0);
        chk_bank("R2 bank unchanged");
        addr_sel = 1'b0;
        repeat (4) @(negedge clk);

        // R6/R7 status read burst
        wr_tx(DEV0, 8'h05, 1, 32'h3C00_0000, acks);
        model_write(8'h05, 8'h3C);
        rd_tx(DEV0, 8'h28, 5, got, acks);
        chk(acks == 3, "R6 read header acked", acks, 3);
        chk(got[39:32] == 8'h91, "R6 status 28h", {24'h0, got[39:32]}, 32'h91);
        chk(got[31:24] == 8'h00, "R7 gap 29h zero", {24'h0, got[31:24]}, 32'h00);
        chk(got[23:16] == 8'hA2, "R6 status 2Ah", {24'h0, got[23:16]}, 32'hA2);
        chk(got[15:8]  == 8'hB3, "R6 status 2Bh", {24'h0, got[15:8]}, 32'hB3);
        chk(got[7:0]   == 8'hC4, "R6 status 2Ch", {24'h0, got[7:0]}, 32'hC4);

        rd_tx(DEV0, 8'h05, 1, got, acks);
        chk(got[39:32] == 8'h00, "R7 control register reads zero", {24'h0, got[39:32]}, 32'h00);

        status_i = 32'h5E00_0000;
        repeat (4) @(negedge clk);
        rd_tx(DEV0, 8'h2C, 1, got, acks);
        chk(got[39:32] == 8'h5E, "R6 live status 2Ch", {24'h0, got[39:32]}, 32'h5E);

        // R9 bytes after STOP without START are ignored
        wr_tx(DEV0, 8'h07, 1, 32'h1100_0000, acks);
        model_write(8'h07, 8'h11);
        write_byte({DEV0, 1'b0}, a);
        chk(a == 1'b0, "R9 no ack without START", {31'h0, a}, 32'h0);
        write_byte(8'h07, a);
        write_byte(8'hEE, a);
        i2c_stop();
        qw();
        chk_bank("R9 bank unchanged after stray bytes");

        // R10 drive stable during SCL high
        chk(r10_glitch == 0, "R10 SDA stable while SCL high", r10_glitch, 0);

        // R8 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        reset_model();
        chk_bank("R8 reset restores values");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule